// File: doc/BRIEF.md
# Port-Sized Bus Beat Acknowledge Sequencer

This block sits on the slave side of a 64-bit synchronous system bus. It produces the data-phase handshakes for one transfer at a time. A master asks for a single word, a pair of words, or an eight-word burst. The attached device has a data port that is 64, 32, 16 or 8 bits wide. The sequencer works out how many port-sized beats the transfer needs. It raises a beat-valid strobe on every cycle in which the device is ready and a beat moves. It raises the transfer acknowledge only where the protocol terminates the transfer, or on every word of a full-width burst.

Two protections sit beside the sequencer. A stall watchdog counts consecutive cycles in which the device is not ready. When that count reaches a limit set on an input, the watchdog ends the transfer with an error strobe. A byte-lane parity unit creates odd parity for write data. It also checks the parity of read data lane by lane and keeps a sticky error flag until that flag is cleared.

Top module: `beat_ack_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, busy, beat_vld, xfer_ack, xfer_err and perr_sticky are all 0.
- R2: An accepted request moves a number of beats equal to its bytes divided by the port width in bytes. The req_kind encoding is 00 = single (8 bytes), 01 = double word (16 bytes), 10 = burst (64 bytes), and 11 is handled as single. The port_width encoding is 00 = 64-bit, 01 = 32-bit, 10 = 16-bit, 11 = 8-bit.
- R3: beat_vld is high only while busy is high and dev_ready is high. Every cycle with xfer_ack also has beat_vld.
- R4: For single and double-word transfers, and for bursts on a narrow port, xfer_ack is high only on the final beat. For a burst on a 64-bit port, xfer_ack is high on each of the 8 beats.
- R5: A request sampled with req_valid while the block is idle sets busy from the next cycle. busy falls in the cycle after the final beat or after xfer_err.
- R6: req_valid while busy is ignored. The current transfer keeps its beat count, and no new transfer starts when it ends.
- R7: With wd_limit = N > 0, xfer_err is high for one cycle on the N-th consecutive cycle of busy with dev_ready low, and the transfer then ends. Any beat restarts the count. wd_limit = 0 turns the watchdog off.
- R8: xfer_err and xfer_ack are never high in the same cycle.
- R9: wr_par[i] is set so that wr_par[i] together with wr_data[8i+7:8i] holds an odd number of ones.
- R10: When rd_chk is high and any lane i has an even number of ones in {rd_par[i], rd_data[8i+7:8i]}, perr_sticky reads 1 from the next cycle. It stays at 1 until perr_clr is high in a cycle with no new error. If a new error and perr_clr arrive in the same cycle, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, taken only when idle |
| req_kind | input | 2 | Transfer size code |
| port_width | input | 2 | Device port width code |
| dev_ready | input | 1 | Device can move a beat this cycle |
| wd_limit | input | WD_W | Stall limit in cycles, 0 turns the watchdog off |
| busy | output | 1 | A transfer is in progress |
| beat_vld | output | 1 | A port beat moves this cycle |
| xfer_ack | output | 1 | Transfer acknowledge |
| xfer_err | output | 1 | Transfer error acknowledge (stall timeout) |
| wr_data | input | DATA_W | Write data driven by the slave side |
| wr_par | output | DATA_W/8 | Odd parity per write byte lane |
| rd_data | input | DATA_W | Read data received |
| rd_par | input | DATA_W/8 | Received parity per byte lane |
| rd_chk | input | 1 | Read data and parity are valid to check |
| perr_clr | input | 1 | Write-one-to-clear for the parity flag |
| perr_sticky | output | 1 | Sticky read parity error |

## Verification
The assertions are evaluated on every cycle and cover the following:
- the beat counter steps down by exactly one on each non-final beat;
- a request arriving mid-transfer never reloads the counter;
- the error and acknowledge strobes are never high together;
- the strobes never appear while idle;
- the stall count stays below its limit;
- the parity flag sets after a bad check and holds until it is cleared.

The per-transfer totals can only be shown by the bench scenarios. These include the beat count for each kind and width pair, where the acknowledges land, the exact stall cycle at which the error fires, the watchdog being turned off, and the encoded parity values.

// File: rtl/bas_pkg.sv
`timescale 1ns/1ps
package bas_pkg;

    typedef enum logic [1:0] {
        XK_SINGLE = 2'b00,
        XK_DWORD  = 2'b01,
        XK_BURST  = 2'b10,
        XK_RSVD   = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        PW_FULL    = 2'b00,
        PW_HALF    = 2'b01,
        PW_QUARTER = 2'b10,
        PW_EIGHTH  = 2'b11
    } port_width_e;

    // log2 of the number of bus words in a burst
    localparam int BURST_WORDS_LOG = 3;
    // largest beat count: burst on the narrowest port
    localparam int MAX_BEATS       = (1 << BURST_WORDS_LOG) << 3;
    localparam int BEAT_CNT_W      = $clog2(MAX_BEATS) + 1;

    typedef struct packed {
        logic [BEAT_CNT_W-1:0] beats;
        logic                  ack_each;
    } xfer_plan_t;

    typedef struct packed {
        logic                  active;
        logic                  ack_each;
        logic [BEAT_CNT_W-1:0] remain;
    } seq_state_t;

    // beats = words << (port narrowing); acknowledge every beat only for a full-width burst
    function automatic xfer_plan_t plan_xfer(xfer_kind_e k, port_width_e w);
        xfer_plan_t p;
        int         words_log;
        case (k)
            XK_DWORD: words_log = 1;
            XK_BURST: words_log = BURST_WORDS_LOG;
            default:  words_log = 0;
        endcase
        p.beats    = BEAT_CNT_W'(1) << (words_log + int'(w));
        p.ack_each = (k == XK_BURST) && (w == PW_FULL);
        return p;
    endfunction

    // parity bit that makes the 9-bit group odd
    function automatic logic odd_fill(logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/bas_xfer_ctl.sv
`timescale 1ns/1ps
module bas_xfer_ctl
    import bas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic [1:0] port_width,
    input  logic       dev_ready,
    input  logic       timeout,
    output logic       busy,
    output logic       beat_vld,
    output logic       xfer_ack
);

    seq_state_t st, st_nxt;
    xfer_plan_t plan;
    logic       last_beat;

    always_comb begin
        plan      = plan_xfer(xfer_kind_e'(req_kind), port_width_e'(port_width));
        last_beat = (st.remain == BEAT_CNT_W'(1));
        busy      = st.active;
        beat_vld  = st.active && dev_ready;
        xfer_ack  = beat_vld && (st.ack_each || last_beat);
    end

    always_comb begin
        st_nxt = st;
        if (!st.active) begin
            if (req_valid) begin
                st_nxt.active   = 1'b1;
                st_nxt.remain   = plan.beats;
                st_nxt.ack_each = plan.ack_each;
            end
        end else if (timeout) begin
            st_nxt = '0;
        end else if (dev_ready) begin
            st_nxt.remain = st.remain - BEAT_CNT_W'(1);
            if (last_beat) begin
                st_nxt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= st_nxt;
        end
    end

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && !timeout && dev_ready && st.remain > BEAT_CNT_W'(1))
        |=> (st.active && st.remain == $past(st.remain) - BEAT_CNT_W'(1)));

    // R6
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && req_valid) |=> (st.remain <= $past(st.remain)));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && dev_ready && last_beat) |=> !st.active);

endmodule

// File: rtl/bas_stall_wd.sv
`timescale 1ns/1ps
module bas_stall_wd #(
    parameter int WD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            dev_ready,
    input  logic [WD_W-1:0] limit,
    output logic            expire
);

    logic [WD_W-1:0] stall_cnt;

    always_comb begin
        expire = active && !dev_ready && (limit != '0)
                 && (stall_cnt >= limit - WD_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !active || dev_ready || expire) begin
            stall_cnt <= '0;
        end else begin
            stall_cnt <= stall_cnt + WD_W'(1);
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (limit != '0 && $stable(limit)) |-> (stall_cnt < limit));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (stall_cnt == '0));

endmodule

// File: rtl/bas_lane_parity.sv
`timescale 1ns/1ps
module bas_lane_parity
    import bas_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES*8-1:0] wr_data,
    output logic [LANES-1:0]   wr_par,
    input  logic [LANES*8-1:0] rd_data,
    input  logic [LANES-1:0]   rd_par,
    input  logic               rd_chk,
    input  logic               perr_clr,
    output logic               perr_sticky
);

    logic [LANES-1:0] lane_bad;
    logic             any_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_par[i]   = odd_fill(wr_data[8*i +: 8]);
        assign lane_bad[i] = ~^{rd_par[i], rd_data[8*i +: 8]};
    end

    assign any_bad = rd_chk && (|lane_bad);

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_sticky <= 1'b0;
        end else if (any_bad) begin
            perr_sticky <= 1'b1;
        end else if (perr_clr) begin
            perr_sticky <= 1'b0;
        end
    end

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        any_bad |=> perr_sticky);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (perr_sticky && !any_bad && !perr_clr) |=> perr_sticky);

endmodule

// File: rtl/beat_ack_seq.sv
`timescale 1ns/1ps
module beat_ack_seq
    import bas_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WD_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [1:0]          port_width,
    input  logic                dev_ready,
    input  logic [WD_W-1:0]     wd_limit,
    output logic                busy,
    output logic                beat_vld,
    output logic                xfer_ack,
    output logic                xfer_err,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_par,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [DATA_W/8-1:0] rd_par,
    input  logic                rd_chk,
    input  logic                perr_clr,
    output logic                perr_sticky
);

    localparam int LANES = DATA_W / 8;

    logic timeout;

    bas_xfer_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .port_width (port_width),
        .dev_ready  (dev_ready),
        .timeout    (timeout),
        .busy       (busy),
        .beat_vld   (beat_vld),
        .xfer_ack   (xfer_ack)
    );

    bas_stall_wd #(.WD_W(WD_W)) u_wd (
        .clk       (clk),
        .rst       (rst),
        .active    (busy),
        .dev_ready (dev_ready),
        .limit     (wd_limit),
        .expire    (timeout)
    );

    assign xfer_err = timeout;

    bas_lane_parity #(.LANES(LANES)) u_par (
        .clk         (clk),
        .rst         (rst),
        .wr_data     (wr_data),
        .wr_par      (wr_par),
        .rd_data     (rd_data),
        .rd_par      (rd_par),
        .rd_chk      (rd_chk),
        .perr_clr    (perr_clr),
        .perr_sticky (perr_sticky)
    );

    // R8
    err_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_err && xfer_ack));

    // R3
    vld_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        beat_vld |-> busy);

    // R5
    err_ends_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_err |=> !busy);

endmodule

// File: tb/beat_ack_seq_test.sv
`timescale 1ns/1ps
module beat_ack_seq_test;

    localparam int DATA_W = 64;
    localparam int WD_W   = 8;
    localparam int LANES  = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'b00;
    logic [1:0]        port_width = 2'b00;
    logic              dev_ready = 1'b0;
    logic [WD_W-1:0]   wd_limit = 8'd255;
    logic              busy, beat_vld, xfer_ack, xfer_err;
    logic [DATA_W-1:0] wr_data = '0;
    logic [LANES-1:0]  wr_par;
    logic [DATA_W-1:0] rd_data = '0;
    logic [LANES-1:0]  rd_par = '0;
    logic              rd_chk = 1'b0;
    logic              perr_clr = 1'b0;
    logic              perr_sticky;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    beat_ack_seq #(.DATA_W(DATA_W), .WD_W(WD_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .port_width(port_width), .dev_ready(dev_ready), .wd_limit(wd_limit),
        .busy(busy), .beat_vld(beat_vld), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
        .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data), .rd_par(rd_par),
        .rd_chk(rd_chk), .perr_clr(perr_clr), .perr_sticky(perr_sticky)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [LANES-1:0] good_par(input logic [DATA_W-1:0] d);
        logic [LANES-1:0] p;
        for (int i = 0; i < LANES; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(d[8*i+b]);
            p[i] = (ones % 2 == 0);
        end
        return p;
    endfunction

    task automatic reset_case();
        rst = 1'b1;
        dev_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy in reset", busy, 0);
        chk("R1 strobes in reset", {beat_vld, xfer_ack, xfer_err}, 0);
        rst = 1'b0;
        dev_ready = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 busy after reset", busy, 0);
        chk("R1 perr after reset", perr_sticky, 0);
    endtask

    // mode 0: always ready; mode 1: ready on odd cycles. poke: request while busy (R6)
    task automatic run_xfer(input logic [1:0] k, input logic [1:0] w, input int exp_beats,
                            input int exp_acks, input int mode, input bit poke);
        int  beats = 0, acks = 0, vonly = 0, last_ack = 0, cyc = 0;
        bit  bad_pair = 0, saw_err = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; port_width = w; dev_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 busy after accept", busy, 1);
        while (busy && cyc < 400) begin
            dev_ready = (mode == 0) ? 1'b1 : 1'(cyc % 2);
            if (poke && cyc == 1) begin
                req_valid = 1'b1; req_kind = 2'b10; port_width = 2'b11;
            end else begin
                req_valid = 1'b0;
            end
            #2;
            if (beat_vld) beats++;
            if (beat_vld && !xfer_ack) vonly++;
            if (xfer_ack) begin
                acks++;
                last_ack = beats;
                if (!beat_vld) bad_pair = 1;
            end
            if (!busy && beat_vld) bad_pair = 1;
            if (xfer_err) saw_err = 1;
            cyc++;
            @(negedge clk);
        end
        dev_ready = 1'b0;
        req_valid = 1'b0;
        chk("R2 beat count", beats, exp_beats);
        chk("R4 ack count", acks, exp_acks);
        chk("R4 last ack on final beat", last_ack, exp_beats);
        chk("R3 valid-only beats", vonly, exp_beats - exp_acks);
        chk("R3 ack without valid", bad_pair, 0);
        chk("R8 no error on clean transfer", saw_err, 0);
        chk("R5 idle after final beat", busy, 0);
        if (poke) begin
            @(negedge clk);
            #1;
            chk("R6 no transfer from busy request", busy, 0);
        end
    endtask

    // single 8-bit (8 beats): 2 beats, s1 stalls, 1 beat, then stall until error
    task automatic wd_run(input logic [WD_W-1:0] lim, input int s1);
        int beats = 0, acks = 0, err_cnt = 0, err_stall = -1, stall = 0, cyc = 0;
        wd_limit = lim;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; port_width = 2'b11; dev_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && cyc < 800) begin
            if (cyc < 2) dev_ready = 1'b1;
            else if (cyc < 2 + s1) dev_ready = 1'b0;
            else if (cyc == 2 + s1) dev_ready = 1'b1;
            else if (lim == 0 && cyc > 2 + s1 + 300) dev_ready = 1'b1;
            else dev_ready = 1'b0;
            stall = dev_ready ? 0 : stall + 1;
            #2;
            if (beat_vld) beats++;
            if (xfer_ack) acks++;
            if (xfer_err) begin
                err_cnt++;
                err_stall = stall;
            end
            cyc++;
            @(negedge clk);
        end
        dev_ready = 1'b0;
        if (lim != 0) begin
            chk("R7 one error strobe", err_cnt, 1);
            chk("R7 error on limit-th stall", err_stall, lim);
            chk("R7 beats before timeout", beats, 3);
            chk("R8 no ack on timed-out transfer", acks, 0);
        end else begin
            chk("R7 disabled watchdog no error", err_cnt, 0);
            chk("R7 disabled watchdog completes", beats, 8);
            chk("R4 ack after long stall", acks, 1);
        end
        chk("R7 idle after end", busy, 0);
        wd_limit = 8'd255;
    endtask

    task automatic wr_par_case(input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_data = d;
        #1;
        chk("R9 write parity", wr_par, good_par(d));
    endtask

    task automatic rd_case(input string tag, input logic [DATA_W-1:0] d, input logic [LANES-1:0] p,
                           input logic c, input logic clr, input logic exp);
        @(negedge clk);
        rd_data = d; rd_par = p; rd_chk = c; perr_clr = clr;
        @(negedge clk);
        rd_chk = 1'b0; perr_clr = 1'b0;
        #1;
        chk(tag, perr_sticky, exp);
    endtask

    initial begin
        #1_000_000;
        errs++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        reset_case();
        run_xfer(2'b00, 2'b00, 1, 1, 0, 0);
        run_xfer(2'b01, 2'b01, 4, 1, 0, 0);
        run_xfer(2'b01, 2'b00, 2, 1, 1, 0);
        run_xfer(2'b10, 2'b00, 8, 8, 0, 0);
        run_xfer(2'b10, 2'b00, 8, 8, 1, 0);
        run_xfer(2'b10, 2'b11, 64, 1, 0, 1);
        run_xfer(2'b10, 2'b10, 32, 1, 1, 0);
        run_xfer(2'b00, 2'b11, 8, 1, 1, 1);
        run_xfer(2'b11, 2'b10, 4, 1, 0, 0);
        wd_run(8'd5, 4);
        wd_run(8'd1, 0);
        wd_run(8'd0, 10);
        wr_par_case(64'h0);
        wr_par_case(64'hFFFF_FFFF_FFFF_FFFF);
        wr_par_case(64'h0123_4567_89AB_CDEF);
        wr_par_case(64'h8000_0001_7E00_00C3);
        d = 64'hA5C3_0F12_3456_789A;
        rd_case("R10 good data no flag", d, good_par(d), 1'b1, 1'b0, 1'b0);
        rd_case("R10 bad lane sets flag", d, good_par(d) ^ 8'h08, 1'b1, 1'b0, 1'b1);
        rd_case("R10 flag sticky", d, good_par(d), 1'b1, 1'b0, 1'b1);
        rd_case("R10 clear drops flag", d, good_par(d), 1'b0, 1'b1, 1'b0);
        rd_case("R10 unchecked bad data ignored", d, ~good_par(d), 1'b0, 1'b0, 1'b0);
        rd_case("R10 error beats clear", d, good_par(d) ^ 8'h80, 1'b1, 1'b1, 1'b1);
        rd_case("R10 clear again", d, good_par(d), 1'b0, 1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule